// File: doc/BRIEF.md
# Write-Protect Key Sequencer

This block sits in front of the page-write controller of a paged nonvolatile memory. It watches every byte write (address and data) and decides whether that write may reach the page buffer. It also tracks a protection flag that models a nonvolatile bit. While the flag is clear, every ordinary write goes through. While the flag is set, ordinary writes are refused unless a three-write key has just opened a window for a single page load.

The key writes are recognised in order. Each one is marked as a command byte and never reaches the array. The three-write lock key does two things: it sets the flag whatever its previous value was, and it opens the window. The window closes when the controller reports, through `page_done`, that the page has been committed. A six-write clear key arms a release, and the flag drops only once the next programming cycle has completed. Two resets are provided. `por_n` models a power-on with a fresh, unprotected part. `rst_n` only restarts the sequencer, so the flag survives it.

Top module: `swp_guard`

## Requirements
- R1: While `por_n` is low, `prot_on` is 0. `rst_n` low clears the key tracker, the window and an armed release, but leaves `prot_on` unchanged.
- R2: With `prot_on` = 0, every write that is not a command byte has `wr_permit` = 1.
- R3: With `prot_on` = 1 and no window open, every non-command write has `wr_permit` = 0.
- R4: The lock key is the writes 0xAA to 0x1555, 0x55 to 0x0AAA and 0xA0 to 0x1555, in that order. At the clock edge of its third write, `prot_on` becomes 1 (from either value) and a window opens.
- R5: In an open window, the first PAGE_BYTES (64) data writes are permitted and any further ones are blocked. Key detection is suspended while the window is open, so 0xAA to 0x1555 is a plain data write there.
- R6: A cycle with `page_done` = 1 closes the window. Later writes are blocked while `prot_on` stays 1.
- R7: The clear key is 0xAA to 0x1555, 0x55 to 0x0AAA, 0x80 to 0x1555, 0xAA to 0x1555, 0x55 to 0x0AAA and 0x20 to 0x1555. After it, `prot_on` stays 1 until the edge that samples the next `page_done` = 1, and is 0 from that edge on.
- R8: A write that matches the next expected key step has `wr_cmd` = 1 and `wr_permit` = 0.
- R9: A write that does not match the next expected step has `wr_cmd` = 0 and is judged as a data write. The tracker returns to the first step, so a full key sent afterwards is recognised.
- R10: `prot_on` keeps its value across an `rst_n` pulse. A partial key interrupted by `rst_n` is forgotten.
- R11: Cycles with `wr_valid` = 0 neither advance nor abort a key in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, clears the protection flag |
| rst_n | input | 1 | Sequencer reset, active low, keeps the flag |
| wr_valid | input | 1 | A byte write is presented this cycle |
| wr_addr | input | 13 | Write address |
| wr_data | input | 8 | Write data |
| page_done | input | 1 | Programming cycle of the loaded page has completed |
| wr_permit | output | 1 | The presented write may be loaded into the page buffer |
| wr_cmd | output | 1 | The presented write is a key byte, not array data |
| prot_on | output | 1 | Protection flag |

## Verification
Wrong state in the key tracker shows up in the same cycle as the next write. That write carries the wrong `wr_cmd`, or a key step fails to change `prot_on` one edge later. An error in the window counter shows up as a 65th byte that is permitted, or as an early refusal, on that very write. A flag that is lost or set out of turn is visible on `prot_on` at the next edge and on `wr_permit` of every write after it. The checks therefore sample both outputs on each write and sample `prot_on` after each key and each `page_done`.

// File: rtl/swp_pkg.sv
package swp_pkg;
   // position reached in a key sequence
   typedef enum logic [2:0] {
      ST_IDLE, ST_K1, ST_K2, ST_K3, ST_K4, ST_K5
   } swp_step_e;

   // classification of a single write against the key table
   typedef enum logic [2:0] {
      KM_NONE, KM_OPEN_P, KM_OPEN_Q, KM_LOCK, KM_ARM, KM_FREE
   } swp_key_e;
endpackage

// File: rtl/swp_key_match.sv
module swp_key_match
   import swp_pkg::*;
#(
   parameter int unsigned ADDR_W = 13,
   parameter int unsigned DATA_W = 8,
   parameter logic [ADDR_W-1:0] KEY_ADDR_P = 'h1555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_Q = 'h0AAA,
   parameter logic [DATA_W-1:0] CODE_P1    = 'hAA,
   parameter logic [DATA_W-1:0] CODE_P2    = 'h55,
   parameter logic [DATA_W-1:0] CODE_LOCK  = 'hA0,
   parameter logic [DATA_W-1:0] CODE_ARM   = 'h80,
   parameter logic [DATA_W-1:0] CODE_FREE  = 'h20
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] data_i,
   output swp_key_e          key_o
);
   logic at_p, at_q;
   assign at_p = (addr_i == KEY_ADDR_P);
   assign at_q = (addr_i == KEY_ADDR_Q);

   always_comb begin
      key_o = KM_NONE;
      if (at_q && data_i == CODE_P2)        key_o = KM_OPEN_Q;
      else if (at_p && data_i == CODE_P1)   key_o = KM_OPEN_P;
      else if (at_p && data_i == CODE_LOCK) key_o = KM_LOCK;
      else if (at_p && data_i == CODE_ARM)  key_o = KM_ARM;
      else if (at_p && data_i == CODE_FREE) key_o = KM_FREE;
   end
endmodule

// File: rtl/swp_seq_fsm.sv
module swp_seq_fsm
   import swp_pkg::*;
(
   input  logic     clk,
   input  logic     rst_n,
   input  logic     wr_valid_i,
   input  logic     suspend_i,
   input  swp_key_e key_i,
   output logic     is_cmd_o,
   output logic     lock_o,
   output logic     free_o
);
   swp_step_e st_q, st_d;

   always_comb begin
      st_d     = st_q;
      is_cmd_o = 1'b0;
      lock_o   = 1'b0;
      free_o   = 1'b0;
      if (wr_valid_i && !suspend_i) begin
         st_d = ST_IDLE;  // any mismatch falls back to the first step
         unique case (st_q)
            ST_IDLE: if (key_i == KM_OPEN_P) begin st_d = ST_K1; is_cmd_o = 1'b1; end
            ST_K1:   if (key_i == KM_OPEN_Q) begin st_d = ST_K2; is_cmd_o = 1'b1; end
            ST_K2: begin
               if (key_i == KM_LOCK) begin
                  is_cmd_o = 1'b1;
                  lock_o   = 1'b1;
               end else if (key_i == KM_ARM) begin
                  st_d     = ST_K3;
                  is_cmd_o = 1'b1;
               end
            end
            ST_K3:   if (key_i == KM_OPEN_P) begin st_d = ST_K4; is_cmd_o = 1'b1; end
            ST_K4:   if (key_i == KM_OPEN_Q) begin st_d = ST_K5; is_cmd_o = 1'b1; end
            ST_K5:   if (key_i == KM_FREE) begin
               is_cmd_o = 1'b1;
               free_o   = 1'b1;
            end
            default: st_d = ST_IDLE;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end
endmodule

// File: rtl/swp_window.sv
module swp_window #(
   parameter int unsigned PAGE_BYTES = 64,
   parameter bit          LIMIT_PAGE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic open_i,
   input  logic commit_i,
   input  logic data_wr_i,
   output logic win_open_o,
   output logic room_o
);
   localparam int unsigned CNT_W = $clog2(PAGE_BYTES + 1);
   localparam logic [CNT_W-1:0] CAP = CNT_W'(PAGE_BYTES);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        win_open_o <= 1'b0;
      else if (open_i)   win_open_o <= 1'b1;
      else if (commit_i) win_open_o <= 1'b0;
   end

   generate
      if (LIMIT_PAGE) begin : g_limit
         logic [CNT_W-1:0] cnt_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               cnt_q <= '0;
            else if (open_i)
               cnt_q <= '0;
            else if (win_open_o && data_wr_i && room_o)
               cnt_q <= cnt_q + 1'b1;
         end
         assign room_o = (cnt_q < CAP);
      end else begin : g_free
         assign room_o = 1'b1;
      end
   endgenerate
endmodule

// File: rtl/swp_guard.sv
module swp_guard
   import swp_pkg::*;
#(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 64,
   parameter bit          LIMIT_PAGE = 1'b1,
   parameter logic [ADDR_W-1:0] KEY_ADDR_P = 'h1555,
   parameter logic [ADDR_W-1:0] KEY_ADDR_Q = 'h0AAA,
   parameter logic [DATA_W-1:0] CODE_P1    = 'hAA,
   parameter logic [DATA_W-1:0] CODE_P2    = 'h55,
   parameter logic [DATA_W-1:0] CODE_LOCK  = 'hA0,
   parameter logic [DATA_W-1:0] CODE_ARM   = 'h80,
   parameter logic [DATA_W-1:0] CODE_FREE  = 'h20
) (
   input  logic              clk,
   input  logic              por_n,
   input  logic              rst_n,
   input  logic              wr_valid,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic              page_done,
   output logic              wr_permit,
   output logic              wr_cmd,
   output logic              prot_on
);
   generate
      if (PAGE_BYTES < 1)
         $error("swp_guard: PAGE_BYTES must be at least 1");
      if (KEY_ADDR_P == KEY_ADDR_Q)
         $error("swp_guard: the two key addresses must differ");
      if (CODE_LOCK == CODE_ARM)
         $error("swp_guard: lock and arm codes must differ");
   endgenerate

   logic     seq_rst_n;
   swp_key_e key;
   logic     lock_p, free_p;
   logic     win_open, room;
   logic     free_armed;

   assign seq_rst_n = por_n & rst_n;

   swp_key_match #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W),
      .KEY_ADDR_P(KEY_ADDR_P), .KEY_ADDR_Q(KEY_ADDR_Q),
      .CODE_P1(CODE_P1), .CODE_P2(CODE_P2), .CODE_LOCK(CODE_LOCK),
      .CODE_ARM(CODE_ARM), .CODE_FREE(CODE_FREE)
   ) u_match (
      .addr_i(wr_addr), .data_i(wr_data), .key_o(key)
   );

   swp_seq_fsm u_fsm (
      .clk(clk), .rst_n(seq_rst_n), .wr_valid_i(wr_valid),
      .suspend_i(win_open), .key_i(key),
      .is_cmd_o(wr_cmd), .lock_o(lock_p), .free_o(free_p)
   );

   swp_window #(.PAGE_BYTES(PAGE_BYTES), .LIMIT_PAGE(LIMIT_PAGE)) u_win (
      .clk(clk), .rst_n(seq_rst_n), .open_i(lock_p), .commit_i(page_done),
      .data_wr_i(wr_valid && !wr_cmd), .win_open_o(win_open), .room_o(room)
   );

   // release armed by the clear key, honoured at the next programming completion
   always_ff @(posedge clk or negedge seq_rst_n) begin
      if (!seq_rst_n)     free_armed <= 1'b0;
      else if (lock_p)    free_armed <= 1'b0;
      else if (free_p)    free_armed <= 1'b1;
      else if (page_done) free_armed <= 1'b0;
   end

   // models the nonvolatile bit: only power-on clears it asynchronously
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                       prot_on <= 1'b0;
      else if (lock_p)                  prot_on <= 1'b1;
      else if (free_armed && page_done) prot_on <= 1'b0;
   end

   assign wr_permit = wr_valid && !wr_cmd && (!prot_on || (win_open && room));
endmodule

// File: rtl/swp_guard_chk.sv
module swp_guard_chk #(
   parameter int unsigned ADDR_W     = 13,
   parameter int unsigned DATA_W     = 8,
   parameter int unsigned PAGE_BYTES = 64,
   parameter logic [ADDR_W-1:0] KEY_ADDR_P = 'h1555,
   parameter logic [DATA_W-1:0] CODE_LOCK  = 'hA0
) (
   input logic              clk,
   input logic              por_n,
   input logic              rst_n,
   input logic              wr_valid,
   input logic [ADDR_W-1:0] wr_addr,
   input logic [DATA_W-1:0] wr_data,
   input logic              page_done,
   input logic              wr_permit,
   input logic              wr_cmd,
   input logic              prot_on,
   input logic              win_open
);
   localparam int unsigned CW = $clog2(PAGE_BYTES + 2) + 1;
   localparam logic [CW-1:0] CAP = CW'(PAGE_BYTES);

   logic [CW-1:0] perm_cnt;
   always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)                     perm_cnt <= '0;
      else if (!rst_n || page_done)   perm_cnt <= '0;
      else if (wr_permit && prot_on)  perm_cnt <= perm_cnt + 1'b1;
   end

   p_por_clear_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(por_n) |-> !prot_on);

   p_open_unprot_r2: assert property (@(posedge clk) disable iff (!por_n)
      (wr_valid && !wr_cmd && !prot_on) |-> wr_permit);

   p_locked_block_r3: assert property (@(posedge clk) disable iff (!por_n)
      (prot_on && !win_open) |-> !wr_permit);

   p_lock_sets_r4: assert property (@(posedge clk) disable iff (!por_n)
      (wr_valid && wr_cmd && wr_addr == KEY_ADDR_P && wr_data == CODE_LOCK) |=> prot_on);

   p_window_cap_r5: assert property (@(posedge clk) disable iff (!por_n || !rst_n)
      perm_cnt <= CAP);

   p_free_on_done_r7: assert property (@(posedge clk) disable iff (!por_n)
      $fell(prot_on) |-> $past(page_done));

   p_cmd_blocked_r8: assert property (@(posedge clk) disable iff (!por_n)
      wr_cmd |-> !wr_permit);

   p_flag_hold_r10: assert property (@(posedge clk) disable iff (!por_n)
      (!(wr_valid && wr_cmd) && !page_done) |=> $stable(prot_on));
endmodule

bind swp_guard swp_guard_chk #(
   .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_BYTES(PAGE_BYTES),
   .KEY_ADDR_P(KEY_ADDR_P), .CODE_LOCK(CODE_LOCK)
) u_chk (
   .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid),
   .wr_addr(wr_addr), .wr_data(wr_data), .page_done(page_done),
   .wr_permit(wr_permit), .wr_cmd(wr_cmd), .prot_on(prot_on),
   .win_open(win_open)
);

// File: tb/swp_guard_tb.sv
`timescale 1ns/1ps
module swp_guard_tb;
   logic        clk = 1'b0;
   logic        por_n = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_valid = 1'b0;
   logic [12:0] wr_addr = '0;
   logic [7:0]  wr_data = '0;
   logic        page_done = 1'b0;
   logic        wr_permit, wr_cmd, prot_on;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   swp_guard u_dut (
      .clk(clk), .por_n(por_n), .rst_n(rst_n), .wr_valid(wr_valid),
      .wr_addr(wr_addr), .wr_data(wr_data), .page_done(page_done),
      .wr_permit(wr_permit), .wr_cmd(wr_cmd), .prot_on(prot_on)
   );

   task automatic chk(input string req, input logic act, input logic exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
      end
   endtask

   // one write; outputs are combinational, sampled 1 ns after driving
   task automatic wr(input logic [12:0] a, input logic [7:0] d,
                     input logic ep, input logic ec, input string req);
      @(negedge clk);
      wr_valid = 1'b1; wr_addr = a; wr_data = d;
      #1;
      chk({req, " permit"}, wr_permit, ep);
      chk({req, " cmd"}, wr_cmd, ec);
      @(posedge clk);
      #1 wr_valid = 1'b0;
   endtask

   task automatic pchk(input logic exp, input string req);
      @(negedge clk);
      chk({req, " prot_on"}, prot_on, exp);
   endtask

   task automatic done_pulse();
      @(negedge clk); page_done = 1'b1;
      @(posedge clk); #1 page_done = 1'b0;
   endtask

   task automatic unlock(input string req);
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, req);
      wr(13'h0AAA, 8'h55, 1'b0, 1'b1, req);
      wr(13'h1555, 8'hA0, 1'b0, 1'b1, req);
   endtask

   initial begin
      // R1: reset state
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk("R1 reset", prot_on, 1'b0);
      chk("R1 reset permit idle", wr_permit, 1'b0);
      por_n = 1'b1; rst_n = 1'b1;

      // R2: unprotected sweep of every data value
      for (int d = 0; d < 256; d++)
         wr(13'h0100, 8'(d), 1'b1, 1'b0, "R2 open sweep");
      // R8 and R9 while unprotected
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R8 key byte unprotected");
      wr(13'h0000, 8'h33, 1'b1, 1'b0, "R9 abort is data");
      pchk(1'b0, "R2 still open");

      // R4 with R11 idle cycles inside the key
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R4 step1");
      repeat (3) @(posedge clk);
      wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R11 step2 after idle");
      wr(13'h1555, 8'hA0, 1'b0, 1'b1, "R4 step3");
      pchk(1'b1, "R4 lock set");

      // R5: window, key suspended, cap at 64
      wr(13'h1555, 8'hAA, 1'b1, 1'b0, "R5 key suspended in window");
      for (int i = 1; i < 64; i++)
         wr(13'(13'h0200 + i), 8'(i), 1'b1, 1'b0, "R5 window byte");
      wr(13'h0300, 8'h01, 1'b0, 1'b0, "R5 byte 65 blocked");

      // R6
      done_pulse();
      pchk(1'b1, "R6 flag after commit");
      wr(13'h0300, 8'h11, 1'b0, 1'b0, "R6 blocked after commit");

      // R3: address sweep while locked
      for (int a = 0; a < 8192; a++)
         wr(13'(a), 8'h5A, 1'b0, 1'b0, "R3 locked address sweep");
      // R8/R9: data sweep at the key address while locked
      for (int d = 0; d < 256; d++)
         wr(13'h1555, 8'(d), 1'b0, (d == 8'hAA), "R8 data sweep key addr");

      // R9: mismatch mid-key, then a clean key
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R9 start");
      wr(13'h1555, 8'hAA, 1'b0, 1'b0, "R9 mismatch aborts");
      wr(13'h0AAA, 8'h55, 1'b0, 1'b0, "R9 no resume");
      unlock("R9 clean key");
      wr(13'h0400, 8'h77, 1'b1, 1'b0, "R9 window after clean key");
      done_pulse();
      pchk(1'b1, "R6 stays locked");

      // R10: rst_n keeps flag and forgets partial key
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R10 partial 1");
      wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R10 partial 2");
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); rst_n = 1'b1;
      pchk(1'b1, "R10 flag kept");
      wr(13'h1555, 8'hA0, 1'b0, 1'b0, "R10 partial forgotten");
      pchk(1'b1, "R10 flag kept after");

      // R7: clear key
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R7 c1");
      wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R7 c2");
      wr(13'h1555, 8'h80, 1'b0, 1'b1, "R7 c3");
      wr(13'h1555, 8'hAA, 1'b0, 1'b1, "R7 c4");
      wr(13'h0AAA, 8'h55, 1'b0, 1'b1, "R7 c5");
      wr(13'h1555, 8'h20, 1'b0, 1'b1, "R7 c6");
      pchk(1'b1, "R7 held until done");
      wr(13'h0500, 8'h42, 1'b0, 1'b0, "R7 blocked until done");
      done_pulse();
      pchk(1'b0, "R7 released");
      wr(13'h0500, 8'h42, 1'b1, 1'b0, "R7 open after release");

      // R1: power-on clears a set flag
      unlock("R1 relock");
      done_pulse();
      pchk(1'b1, "R1 locked before por");
      @(negedge clk); por_n = 1'b0;
      @(negedge clk);
      chk("R1 por clears prot_on", prot_on, 1'b0);
      por_n = 1'b1;
      wr(13'h0600, 8'h99, 1'b1, 1'b0, "R1 open after por");

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         fails++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end
endmodule